// File: doc/BRIEF.md
# Synchronous Burst SRAM Controller

This block is a synthesizable model of a single-ported synchronous SRAM with four-beat burst addressing. Every control input is sampled on the rising clock edge. In each cycle the block decides whether the access is a deselect, a burst start, a burst step or a burst pause. It then reads or writes a 32-bit word of an internal array, with a write mask for each byte lane.

A burst can be started by one of two strobes. The host strobe always starts a read, and it only counts while the main chip enable is low. The control strobe loads an address for either a read or a write. Once a burst has started, the step input moves through the remaining beats. Only the two low address bits change, either in XOR order or in wrapping linear order. The upper bits stay fixed. Read data comes out one clock after the access and is driven only while the output enable is low. Separate write-data, read-data and drive-enable ports take the place of a shared bidirectional bus.

The output-phase state machine has three states:
- `ST_IDLE` is entered on reset and on every deselect cycle.
- `ST_READ` is entered on any non-deselect cycle with no byte lane enabled for writing.
- `ST_WRITE` is entered on any non-deselect cycle that writes at least one lane.

Each cycle moves to exactly one of these three states from any state. The only state that drives data is `ST_READ`.

Top module: `burst_sram_ctrl`

## Requirements
- R1: A cycle is a deselect in two cases, and a deselect writes nothing and drives nothing on the next cycle. Case one: the host strobe is low, `en_main_n` is low, and either `en_pos` is low or `en_neg_n` is high. Case two: the host strobe is not taken, the control strobe is low, and any enable is inactive.
- R2: The host strobe is taken when `strb_host_n` is low with `en_main_n` low. If it is taken with all enables active (`en_main_n`=0, `en_pos`=1, `en_neg_n`=0), the cycle starts a burst at `addr` and is always a read, whatever the write inputs say.
- R3: While `en_main_n` is high, `strb_host_n` is ignored. With `strb_ctrl_n` high, the cycle is then a step or a pause.
- R4: If `strb_ctrl_n` is low, the host strobe is not taken, and all enables are active, the cycle starts a burst at `addr`. It reads or writes as R6 decides.
- R5: With both strobes inactive, a low `step_n` moves to the next beat and a high `step_n` repeats the current address. In both cases the cycle reads or writes as R6 decides.
- R6: Write mask. `wr_all_n`=0 writes all four lanes. Otherwise, `wr_lane_en_n`=0 writes lane k exactly where `lane_wr_n[k]`=0, with lane k being `wdata[8k+7:8k]`. With no lane selected, the cycle is a read.
- R7: `rdata_drive` is high only while `out_en_n` is low and the previous cycle was a read. While `rdata_drive` is low, `rdata` is zero.
- R8: With `seq_xor`=1, the low two address bits of beat b are the starting low bits XOR b. For example, a start of 01 gives 01, 00, 11, 10.
- R9: With `seq_xor`=0, the low two bits of beat b are the starting low bits plus b, modulo 4. The upper address bits are fixed for the whole burst in both orders.
- R10: After the fourth beat, the next step returns to the starting address. The same four addresses repeat until a new burst is started.
- R11: Read data and `rdata_drive` appear after the clock edge that samples the read cycle, not before it.
- R12: Reset (`rst_n` low, asynchronous) returns the state machine to `ST_IDLE`, so `rdata_drive` is low at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | ADDR_W | Word address for a burst start |
| en_main_n | input | 1 | Main chip enable, active low; also qualifies the host strobe |
| en_pos | input | 1 | Secondary chip enable, active high |
| en_neg_n | input | 1 | Secondary chip enable, active low |
| strb_host_n | input | 1 | Host address strobe, read-only start, active low |
| strb_ctrl_n | input | 1 | Control address strobe, active low |
| step_n | input | 1 | Burst advance, active low |
| wr_all_n | input | 1 | Write all lanes, active low |
| wr_lane_en_n | input | 1 | Enables per-lane writes, active low |
| lane_wr_n | input | LANES | Per-lane write select, active low |
| out_en_n | input | 1 | Read output enable, active low |
| seq_xor | input | 1 | Burst order: 1 XOR order, 0 linear order |
| wdata | input | LANES*LANE_W | Write data |
| rdata | output | LANES*LANE_W | Read data, zero when not driven |
| rdata_drive | output | 1 | Read data valid and driven |

## Verification
A wrong burst counter shows up as the wrong word on `rdata` in the cycle right after the step that used it. Wrong start or hold bookkeeping shows the same way one cycle later. A corrupted write mask stays hidden until the affected word is read back, so byte-lane writes are always followed by a read of the same address. A state machine stuck in or out of `ST_READ` shows on `rdata_drive` within one clock, while `out_en_n` is low. Decode errors in the enables or strobes are caught in the same cycle against the classified cycle kind, and at the ports one cycle later.

// File: rtl/burst_sram_pkg.sv
package burst_sram_pkg;

    typedef enum logic [2:0] {
        CYC_DESEL     = 3'd0,
        CYC_START_CPU = 3'd1,
        CYC_START_CTL = 3'd2,
        CYC_NEXT      = 3'd3,
        CYC_HOLD      = 3'd4
    } cyc_e;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_READ  = 2'd1,
        ST_WRITE = 2'd2
    } st_e;

    // low two address bits of a beat, for either burst order
    function automatic logic [1:0] beat_lo(input logic [1:0] start,
                                           input logic [1:0] beat,
                                           input logic       use_xor);
        return use_xor ? (start ^ beat) : (start + beat);
    endfunction

endpackage

// File: rtl/burst_cycle_decode.sv
module burst_cycle_decode
    import burst_sram_pkg::*;
#(
    parameter int LANES = 4
) (
    input  logic             en_main_n,
    input  logic             en_pos,
    input  logic             en_neg_n,
    input  logic             strb_host_n,
    input  logic             strb_ctrl_n,
    input  logic             step_n,
    input  logic             wr_all_n,
    input  logic             wr_lane_en_n,
    input  logic [LANES-1:0] lane_wr_n,
    output cyc_e             cyc,
    output logic [LANES-1:0] lane_we,
    output logic             rd_cyc
);

    logic             sel_all;
    logic             host_taken;
    logic [LANES-1:0] mask;

    always_comb begin
        sel_all    = !en_main_n && en_pos && !en_neg_n;
        host_taken = !strb_host_n && !en_main_n;

        if (host_taken) begin
            cyc = sel_all ? CYC_START_CPU : CYC_DESEL;
        end else if (!strb_ctrl_n) begin
            cyc = sel_all ? CYC_START_CTL : CYC_DESEL;
        end else if (step_n) begin
            cyc = CYC_HOLD;
        end else begin
            cyc = CYC_NEXT;
        end
    end

    always_comb begin
        if (!wr_all_n) begin
            mask = '1;
        end else if (!wr_lane_en_n) begin
            mask = ~lane_wr_n;
        end else begin
            mask = '0;
        end
    end

    always_comb begin
        lane_we = ((cyc == CYC_DESEL) || (cyc == CYC_START_CPU)) ? '0 : mask;
        rd_cyc  = (cyc != CYC_DESEL) && (lane_we == '0);
    end

endmodule

// File: rtl/burst_addr_gen.sv
module burst_addr_gen
    import burst_sram_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  cyc_e              cyc,
    input  logic [ADDR_W-1:0] ext_addr,
    input  logic              use_xor,
    output logic [ADDR_W-1:0] acc_addr
);

    localparam int HI_W = ADDR_W - 2;

    logic [HI_W-1:0] hi_q;
    logic [1:0]      start_q;
    logic [1:0]      beat_q;
    logic [1:0]      beat_inc;

    assign beat_inc = beat_q + 2'd1;

    always_comb begin
        unique case (cyc)
            CYC_START_CPU,
            CYC_START_CTL: acc_addr = ext_addr;
            CYC_NEXT:      acc_addr = {hi_q, beat_lo(start_q, beat_inc, use_xor)};
            default:       acc_addr = {hi_q, beat_lo(start_q, beat_q, use_xor)};
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hi_q    <= '0;
            start_q <= 2'd0;
            beat_q  <= 2'd0;
        end else begin
            unique case (cyc)
                CYC_START_CPU,
                CYC_START_CTL: begin
                    hi_q    <= ext_addr[ADDR_W-1:2];
                    start_q <= ext_addr[1:0];
                    beat_q  <= 2'd0;
                end
                CYC_NEXT: beat_q <= beat_inc;
                default: ;
            endcase
        end
    end

endmodule

// File: rtl/burst_sram_array.sv
module burst_sram_array #(
    parameter int ADDR_W = 8,
    parameter int LANES  = 4,
    parameter int LANE_W = 8
) (
    input  logic                    clk,
    input  logic [ADDR_W-1:0]       addr,
    input  logic [LANES-1:0]        lane_we,
    input  logic                    rd_en,
    input  logic [LANES*LANE_W-1:0] wdata,
    output logic [LANES*LANE_W-1:0] rd_word
);

    localparam int DEPTH = 1 << ADDR_W;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic [LANE_W-1:0] lane_mem [DEPTH];
        logic [LANE_W-1:0] lane_q;

        always_ff @(posedge clk) begin
            if (lane_we[g]) begin
                lane_mem[addr] <= wdata[g*LANE_W +: LANE_W];
            end
            if (rd_en) begin
                lane_q <= lane_mem[addr];
            end
        end

        assign rd_word[g*LANE_W +: LANE_W] = lane_q;
    end

endmodule

// File: rtl/burst_sram_ctrl.sv
module burst_sram_ctrl
    import burst_sram_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int LANES  = 4,
    parameter int LANE_W = 8,
    localparam int DATA_W = LANES * LANE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              en_main_n,
    input  logic              en_pos,
    input  logic              en_neg_n,
    input  logic              strb_host_n,
    input  logic              strb_ctrl_n,
    input  logic              step_n,
    input  logic              wr_all_n,
    input  logic              wr_lane_en_n,
    input  logic [LANES-1:0]  lane_wr_n,
    input  logic              out_en_n,
    input  logic              seq_xor,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    output logic              rdata_drive
);

    cyc_e              cyc_w;
    logic [LANES-1:0]  lane_we;
    logic              rd_cyc;
    logic [ADDR_W-1:0] acc_addr;
    logic [DATA_W-1:0] rd_word;
    st_e               st_q;
    st_e               st_d;

    burst_cycle_decode #(.LANES(LANES)) u_decode (
        .en_main_n    (en_main_n),
        .en_pos       (en_pos),
        .en_neg_n     (en_neg_n),
        .strb_host_n  (strb_host_n),
        .strb_ctrl_n  (strb_ctrl_n),
        .step_n       (step_n),
        .wr_all_n     (wr_all_n),
        .wr_lane_en_n (wr_lane_en_n),
        .lane_wr_n    (lane_wr_n),
        .cyc          (cyc_w),
        .lane_we      (lane_we),
        .rd_cyc       (rd_cyc)
    );

    burst_addr_gen #(.ADDR_W(ADDR_W)) u_addr (
        .clk      (clk),
        .rst_n    (rst_n),
        .cyc      (cyc_w),
        .ext_addr (addr),
        .use_xor  (seq_xor),
        .acc_addr (acc_addr)
    );

    burst_sram_array #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) u_array (
        .clk     (clk),
        .addr    (acc_addr),
        .lane_we (lane_we),
        .rd_en   (rd_cyc),
        .wdata   (wdata),
        .rd_word (rd_word)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= ST_IDLE;
        end else begin
            st_q <= st_d;
        end
    end

    // transitions
    always_comb begin
        unique case (cyc_w)
            CYC_DESEL: st_d = ST_IDLE;
            default:   st_d = rd_cyc ? ST_READ : ST_WRITE;
        endcase
    end

    // outputs
    always_comb begin
        unique case (st_q)
            ST_READ: begin
                rdata_drive = !out_en_n;
                rdata       = out_en_n ? '0 : rd_word;
            end
            default: begin
                rdata_drive = 1'b0;
                rdata       = '0;
            end
        endcase
    end

endmodule

// File: rtl/burst_sram_chk.sv
module burst_sram_chk
    import burst_sram_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int LANES  = 4,
    parameter int LANE_W = 8
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic                    en_main_n,
    input logic                    en_pos,
    input logic                    en_neg_n,
    input logic                    strb_host_n,
    input logic                    strb_ctrl_n,
    input logic                    out_en_n,
    input logic                    seq_xor,
    input logic                    rdata_drive,
    input logic [LANES*LANE_W-1:0] rdata,
    input cyc_e                    cyc,
    input logic [LANES-1:0]        lane_we,
    input logic [ADDR_W-1:0]       acc_addr
);

    logic past_ok;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            past_ok <= 1'b0;
        end else begin
            past_ok <= 1'b1;
        end
    end

    AST_DESEL_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc == CYC_DESEL) |-> (lane_we == '0)); // R1
    AST_DESEL_NO_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc == CYC_DESEL) |=> !rdata_drive); // R1
    AST_HOST_READ_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        (!strb_host_n && !en_main_n && en_pos && !en_neg_n) |-> (cyc == CYC_START_CPU && lane_we == '0)); // R2
    AST_HOST_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (en_main_n && strb_ctrl_n) |-> (cyc == CYC_NEXT || cyc == CYC_HOLD)); // R3
    AST_HOLD_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && cyc == CYC_HOLD && $stable(seq_xor)) |-> $stable(acc_addr)); // R5
    AST_OE_GATES: assert property (@(posedge clk) disable iff (!rst_n)
        out_en_n |-> !rdata_drive); // R7
    AST_UNDRIVEN_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !rdata_drive |-> (rdata == '0)); // R7
    AST_UPPER_FIXED: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && (cyc == CYC_NEXT || cyc == CYC_HOLD)) |-> (acc_addr[ADDR_W-1:2] == $past(acc_addr[ADDR_W-1:2]))); // R9
    AST_READ_NEXT_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && $past(cyc != CYC_DESEL && lane_we == '0) && !out_en_n) |-> rdata_drive); // R11

endmodule

bind burst_sram_ctrl burst_sram_chk #(
    .ADDR_W (ADDR_W),
    .LANES  (LANES),
    .LANE_W (LANE_W)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .en_main_n   (en_main_n),
    .en_pos      (en_pos),
    .en_neg_n    (en_neg_n),
    .strb_host_n (strb_host_n),
    .strb_ctrl_n (strb_ctrl_n),
    .out_en_n    (out_en_n),
    .seq_xor     (seq_xor),
    .rdata_drive (rdata_drive),
    .rdata       (rdata),
    .cyc         (cyc_w),
    .lane_we     (lane_we),
    .acc_addr    (acc_addr)
);

// File: tb/test_burst_sram_ctrl.sv
module test_burst_sram_ctrl;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  addr = 8'h00;
    logic        en_main_n = 1'b0;
    logic        en_pos = 1'b1;
    logic        en_neg_n = 1'b0;
    logic        strb_host_n = 1'b1;
    logic        strb_ctrl_n = 1'b1;
    logic        step_n = 1'b1;
    logic        wr_all_n = 1'b1;
    logic        wr_lane_en_n = 1'b1;
    logic [3:0]  lane_wr_n = 4'hF;
    logic        out_en_n = 1'b0;
    logic        seq_xor = 1'b1;
    logic [31:0] wdata = 32'h0;
    logic [31:0] rdata;
    logic        rdata_drive;

    int n_chk = 0;
    int n_bad = 0;

    always #5 clk = ~clk;

    burst_sram_ctrl i_burst_sram_ctrl (
        .clk, .rst_n, .addr, .en_main_n, .en_pos, .en_neg_n,
        .strb_host_n, .strb_ctrl_n, .step_n, .wr_all_n, .wr_lane_en_n,
        .lane_wr_n, .out_en_n, .seq_xor, .wdata, .rdata, .rdata_drive
    );

    // cycle kinds
    localparam logic [2:0] K_CPU = 3'd0, K_CTL = 3'd1, K_NEXT = 3'd2, K_HOLD = 3'd3,
                           K_DCPU = 3'd4, K_DCTL = 3'd5, K_IGN = 3'd6, K_DCE = 3'd7;
    // write selection
    localparam logic [1:0] W_NO = 2'd0, W_ALL = 2'd1, W_LN = 2'd2;

    typedef struct packed {
        logic [3:0]  rq;
        logic [2:0]  kind;
        logic [1:0]  wsel;
        logic [3:0]  bw;
        logic        oe;
        logic        mode;
        logic [7:0]  a;
        logic [31:0] wd;
        logic        drv;
        logic [31:0] ed;
    } vec_t;

    localparam int NV = 34;
    localparam vec_t TBL [NV] = '{
        '{4'd4,  K_CTL,  W_ALL, 4'hF, 1'b0, 1'b1, 8'h10, 32'h11111111, 1'b0, 32'h0},        // R4 write start
        '{4'd5,  K_NEXT, W_ALL, 4'hF, 1'b0, 1'b1, 8'h00, 32'h22222222, 1'b0, 32'h0},        // R5 step write -> 0x11
        '{4'd5,  K_NEXT, W_ALL, 4'hF, 1'b0, 1'b1, 8'h00, 32'h33333333, 1'b0, 32'h0},        // -> 0x12
        '{4'd5,  K_NEXT, W_ALL, 4'hF, 1'b0, 1'b1, 8'h00, 32'h44444444, 1'b0, 32'h0},        // -> 0x13
        '{4'd2,  K_CPU,  W_ALL, 4'hF, 1'b0, 1'b1, 8'h10, 32'hDEADBEEF, 1'b1, 32'h11111111}, // R2 host start ignores write
        '{4'd8,  K_NEXT, W_NO,  4'hF, 1'b0, 1'b1, 8'h00, 32'h0, 1'b1, 32'h22222222},        // R8
        '{4'd8,  K_NEXT, W_NO,  4'hF, 1'b0, 1'b1, 8'h00, 32'h0, 1'b1, 32'h33333333},
        '{4'd8,  K_NEXT, W_NO,  4'hF, 1'b0, 1'b1, 8'h00, 32'h0, 1'b1, 32'h44444444},
        '{4'd10, K_NEXT, W_NO,  4'hF, 1'b0, 1'b1, 8'h00, 32'h0, 1'b1, 32'h11111111},        // R10 wrap
        '{4'd5,  K_HOLD, W_NO,  4'hF, 1'b0, 1'b1, 8'h00, 32'h0, 1'b1, 32'h11111111},        // R5 hold
        '{4'd7,  K_HOLD, W_NO,  4'hF, 1'b1, 1'b1, 8'h00, 32'h0, 1'b0, 32'h0},               // R7 oe high
        '{4'd2,  K_CPU,  W_NO,  4'hF, 1'b0, 1'b1, 8'h11, 32'h0, 1'b1, 32'h22222222},
        '{4'd8,  K_NEXT, W_NO,  4'hF, 1'b0, 1'b1, 8'h00, 32'h0, 1'b1, 32'h11111111},        // R8 01^01=00
        '{4'd8,  K_NEXT, W_NO,  4'hF, 1'b0, 1'b1, 8'h00, 32'h0, 1'b1, 32'h44444444},        // 01^10=11
        '{4'd8,  K_NEXT, W_NO,  4'hF, 1'b0, 1'b1, 8'h00, 32'h0, 1'b1, 32'h33333333},        // 01^11=10
        '{4'd4,  K_CTL,  W_NO,  4'hF, 1'b0, 1'b0, 8'h11, 32'h0, 1'b1, 32'h22222222},        // R4 read start
        '{4'd9,  K_NEXT, W_NO,  4'hF, 1'b0, 1'b0, 8'h00, 32'h0, 1'b1, 32'h33333333},        // R9 linear
        '{4'd9,  K_NEXT, W_NO,  4'hF, 1'b0, 1'b0, 8'h00, 32'h0, 1'b1, 32'h44444444},
        '{4'd9,  K_NEXT, W_NO,  4'hF, 1'b0, 1'b0, 8'h00, 32'h0, 1'b1, 32'h11111111},        // 01+3 wraps to 00
        '{4'd6,  K_CTL,  W_LN,  4'hE, 1'b0, 1'b0, 8'h12, 32'hAAAAAAAA, 1'b0, 32'h0},        // R6 lane 0
        '{4'd6,  K_CPU,  W_NO,  4'hF, 1'b0, 1'b0, 8'h12, 32'h0, 1'b1, 32'h333333AA},
        '{4'd6,  K_CTL,  W_LN,  4'hF, 1'b0, 1'b0, 8'h12, 32'hFFFFFFFF, 1'b1, 32'h333333AA}, // R6 no lane = read
        '{4'd1,  K_DCPU, W_NO,  4'hF, 1'b0, 1'b1, 8'h10, 32'h0, 1'b0, 32'h0},               // R1
        '{4'd1,  K_DCTL, W_ALL, 4'hF, 1'b0, 1'b1, 8'h10, 32'hFFFFFFFF, 1'b0, 32'h0},        // R1
        '{4'd3,  K_IGN,  W_NO,  4'hF, 1'b0, 1'b1, 8'h55, 32'h0, 1'b1, 32'h44444444},        // R3 10^01=11
        '{4'd1,  K_DCE,  W_ALL, 4'hF, 1'b0, 1'b1, 8'h10, 32'hFFFFFFFF, 1'b0, 32'h0},        // R1
        '{4'd1,  K_CPU,  W_NO,  4'hF, 1'b0, 1'b1, 8'h10, 32'h0, 1'b1, 32'h11111111},        // R1 memory untouched
        '{4'd4,  K_CTL,  W_ALL, 4'hF, 1'b0, 1'b1, 8'h20, 32'h55555555, 1'b0, 32'h0},
        '{4'd5,  K_HOLD, W_ALL, 4'hF, 1'b0, 1'b1, 8'h00, 32'h66666666, 1'b0, 32'h0},        // R5 hold write
        '{4'd5,  K_CPU,  W_NO,  4'hF, 1'b0, 1'b1, 8'h20, 32'h0, 1'b1, 32'h66666666},
        '{4'd9,  K_CTL,  W_NO,  4'hF, 1'b0, 1'b0, 8'h13, 32'h0, 1'b1, 32'h44444444},
        '{4'd9,  K_NEXT, W_NO,  4'hF, 1'b0, 1'b0, 8'h00, 32'h0, 1'b1, 32'h11111111},        // R9 11+1 -> 00
        '{4'd6,  K_CTL,  W_LN,  4'h5, 1'b0, 1'b1, 8'h11, 32'hBBBBBBBB, 1'b0, 32'h0},        // R6 lanes 1,3
        '{4'd6,  K_CPU,  W_NO,  4'hF, 1'b0, 1'b1, 8'h11, 32'h0, 1'b1, 32'hBB22BB22}
    };

    task automatic apply(input vec_t v);
        en_main_n = 1'b0; en_pos = 1'b1; en_neg_n = 1'b0;
        strb_host_n = 1'b1; strb_ctrl_n = 1'b1; step_n = 1'b1;
        case (v.kind)
            K_CPU:  strb_host_n = 1'b0;
            K_CTL:  strb_ctrl_n = 1'b0;
            K_NEXT: step_n = 1'b0;
            K_HOLD: step_n = 1'b1;
            K_DCPU: begin strb_host_n = 1'b0; en_pos = 1'b0; end
            K_DCTL: begin strb_ctrl_n = 1'b0; en_neg_n = 1'b1; end
            K_IGN:  begin en_main_n = 1'b1; en_pos = 1'b0; strb_host_n = 1'b0; step_n = 1'b0; end
            default: begin en_main_n = 1'b1; strb_ctrl_n = 1'b0; end
        endcase
        wr_all_n = (v.wsel != W_ALL);
        wr_lane_en_n = (v.wsel != W_LN);
        lane_wr_n = v.bw;
        out_en_n = v.oe;
        seq_xor = v.mode;
        addr = v.a;
        wdata = v.wd;
    endtask

    task automatic check(input string rq, input logic exp_drv, input logic [31:0] exp_d);
        n_chk++;
        if (rdata_drive !== exp_drv || rdata !== exp_d) begin
            n_bad++;
            $display("FAIL %s: drive=%0b data=%08h expected drive=%0b data=%08h",
                     rq, rdata_drive, rdata, exp_drv, exp_d);
        end
    endtask

    initial begin
        // R12: reset state
        repeat (3) @(negedge clk);
        check("R12", 1'b0, 32'h0);
        rst_n = 1'b1;
        apply(TBL[0]);
        @(negedge clk);
        for (int i = 0; i < NV; i++) begin
            if (i > 0) begin
                apply(TBL[i]);
                @(negedge clk);
            end
            check($sformatf("R%0d row %0d", TBL[i].rq, i), TBL[i].drv,
                  TBL[i].drv ? TBL[i].ed : 32'h0);
        end

        // R11: data only after the sampling edge
        apply('{4'd11, K_CTL, W_ALL, 4'hF, 1'b0, 1'b1, 8'h30, 32'h00000077, 1'b0, 32'h0});
        @(negedge clk);
        check("R11 write", 1'b0, 32'h0);
        apply('{4'd11, K_CPU, W_NO, 4'hF, 1'b0, 1'b1, 8'h30, 32'h0, 1'b1, 32'h77});
        #1;
        check("R11 before edge", 1'b0, 32'h0);
        @(negedge clk);
        check("R11 after edge", 1'b1, 32'h00000077);

        // R7: output enable toggled without a new cycle edge
        out_en_n = 1'b1;
        #1;
        check("R7 oe off", 1'b0, 32'h0);
        out_en_n = 1'b0;
        #1;
        check("R7 oe on", 1'b1, 32'h00000077);

        // R12: asynchronous reset while a read is driving
        rst_n = 1'b0;
        #1;
        check("R12 async", 1'b0, 32'h0);
        @(negedge clk);
        check("R12 held", 1'b0, 32'h0);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: run did not finish, expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule